// File: doc/BRIEF.md
# Inhibit-Guarded Angle Output Latch

This block sits between an up/down angle counter and a host that reads the angle as two byte-wide words. A holding register follows the counter while the counter is idle and no hold is requested. It freezes while the counter signals that it is busy stepping, or while the host pulls its active-low hold request low. The two freeze sources are arbitrated so that the host never sees a word captured during a count change. A hold request that arrives while the counter is busy does not take effect at once. It waits until busy ends, lets one settled word through, and then freezes.

The host reads the angle through two active-low byte enables. The high byte always carries the eight most significant angle bits. The low byte carries the remaining bits left-aligned, and positions beyond the selected resolution (10, 12 or 14 bits) read as zero. Each byte has its own output-enable flag that stands in for a tri-state driver. The resolution select is sampled only when a busy pulse ends, so that a resolution change can never race a count step. The byte interface is plain and carries no valid/ready handshake. A read is complete as soon as the enable is low, and the host cannot apply back-pressure. The host must keep both enables high whenever it is not reading, so that both bytes stay undriven.

Top module: `angle_hold_latch`

## Requirements
- R1: While reset is active and on the first cycle after it, the held word is zero and the captured resolution is the 14-bit setting.
- R2: On a clock edge where busy is low and hold_n is high, the held word takes the value of count_word at that edge.
- R3: On the first edge where hold_n is sampled low while busy is low, the held word captures count_word. It then stays unchanged on every later edge for as long as hold_n remains low.
- R4: On every edge where busy is sampled high, the held word keeps its previous value, whatever the state of hold_n.
- R5: If hold_n goes low while busy is high, no hold lock forms during busy. On the first edge with busy low and hold_n still low, the held word captures count_word once and then freezes.
- R6: On the edge where hold_n is sampled high again with busy low, the held word captures count_word.
- R7: When hi_en_n is low, hi_oe is 1 and hi_byte equals held word bits [13:6], with the most significant angle bit in hi_byte[7].
- R8: When lo_en_n is low, lo_oe is 1 and lo_byte[7:2] carries held word bits [5:0], with the ninth angle bit in lo_byte[7]. lo_byte[1:0] are always 0. Only the top 2, 4 or 6 of those positions are kept for 10-, 12- or 14-bit resolution, and the rest read 0.
- R9: The resolution codes are 2'b00 for 10 bits, 2'b01 for 12 bits, and 2'b10 or 2'b11 for 14 bits. res_sel is captured only on an edge where busy is sampled low after being sampled high on the previous edge; at any other time a change of res_sel has no effect.
- R10: When a byte enable is high, that byte's oe flag is 0 and its data bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_word | input | 14 | Angle from the up/down counter |
| busy | input | 1 | Counter busy strobe, high while a count step is in progress |
| hold_n | input | 1 | Host hold request, active low |
| res_sel | input | 2 | Resolution select code |
| hi_en_n | input | 1 | High byte read enable, active low |
| lo_en_n | input | 1 | Low byte read enable, active low |
| hi_byte | output | 8 | High byte data |
| hi_oe | output | 1 | High byte driven flag |
| lo_byte | output | 8 | Low byte data, masked by resolution |
| lo_oe | output | 1 | Low byte driven flag |

## Verification
The bench targets a hold request that lands inside a busy pulse. A design that locks at once would freeze a stale word, and one that never locks would let the word drift after busy ends. The bench also holds through an entire busy pulse, and releases hold during busy to confirm that capture resumes only after busy falls. It changes res_sel with no busy pulse to catch masking that follows the pin directly, and it walks all four resolution codes against an all-ones word, which exposes a misplaced low-byte mask or a nonzero pad. Finally, it drives long random mixes of busy, hold and enables so that any disagreement on the cycle of capture or freeze shows up as a byte mismatch.

// File: rtl/angle_hold_pkg.sv
package angle_hold_pkg;
  localparam logic [1:0] RES_CODE_10 = 2'b00;
  localparam logic [1:0] RES_CODE_12 = 2'b01;
  localparam logic [1:0] RES_CODE_14 = 2'b10;

  // Resolution in bits for a select code; any code above 12-bit means full width.
  function automatic int res_width(input logic [1:0] code);
    case (code)
      RES_CODE_10: return 10;
      RES_CODE_12: return 12;
      default:     return 14;
    endcase
  endfunction
endpackage

// File: rtl/hold_lock_arbiter.sv
module hold_lock_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic hold_n,
  output logic open_o,
  output logic inh_lock_o,
  output logic busy_fell_o
);
  logic inh_lock_q;
  logic busy_q;

  // Latch is open only when the counter is idle and no hold lock is engaged.
  always_comb open_o = !busy && (hold_n || !inh_lock_q);
  always_comb busy_fell_o = busy_q && !busy;
  assign inh_lock_o = inh_lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_lock_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      // A hold lock forms only outside busy; once formed it survives busy.
      inh_lock_q <= !hold_n && (inh_lock_q || !busy);
      busy_q     <= busy;
    end
  end

  // R5: no new lock may form while busy is high
  assert_no_lock_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !inh_lock_q) |=> !inh_lock_q);

  // R3: an engaged lock persists while hold stays low
  assert_lock_persists_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_lock_q && !hold_n) |=> inh_lock_q);
endmodule

// File: rtl/word_holder.sv
module word_holder #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] held_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_o <= '0;
    else if (open_i) held_o <= word_i;
  end
endmodule

// File: rtl/res_capture.sv
module res_capture
  import angle_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic [1:0] res_sel,
  output logic [1:0] res_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_o <= RES_CODE_14;
    else if (take_i) res_o <= res_sel;
  end
endmodule

// File: rtl/byte_lanes.sv
module byte_lanes
  import angle_hold_pkg::*;
#(
  parameter int ANGLE_W = 14,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] held_i,
  input  logic [1:0]         res_i,
  input  logic               hi_en_n,
  input  logic               lo_en_n,
  output logic [BYTE_W-1:0]  hi_byte,
  output logic               hi_oe,
  output logic [BYTE_W-1:0]  lo_byte,
  output logic               lo_oe
);
  localparam int LO_W  = ANGLE_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LO_W;

  int                kept_lo;
  logic [BYTE_W-1:0] lo_raw;

  always_comb begin
    kept_lo = res_width(res_i);
    if (kept_lo > ANGLE_W) kept_lo = ANGLE_W;
    kept_lo = kept_lo - BYTE_W;
  end

  // Low byte: angle bits below the high byte, left aligned, masked by resolution.
  for (genvar b = 0; b < BYTE_W; b++) begin : g_lo
    if (b >= PAD_W) begin : g_data
      localparam int SRC = b - PAD_W;
      localparam int POS = BYTE_W - 1 - b;
      assign lo_raw[b] = (POS < kept_lo) ? held_i[SRC] : 1'b0;
    end else begin : g_pad
      assign lo_raw[b] = 1'b0;
    end
  end

  assign hi_oe   = !hi_en_n;
  assign lo_oe   = !lo_en_n;
  assign hi_byte = hi_oe ? held_i[ANGLE_W-1 -: BYTE_W] : '0;
  assign lo_byte = lo_oe ? lo_raw : '0;

  // R10: a disabled byte is undriven and quiet
  assert_hi_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en_n |-> (!hi_oe && hi_byte == '0));
  assert_lo_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lo_en_n |-> (!lo_oe && lo_byte == '0));
  // R8: the pad positions below the data never carry a one
  assert_lo_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_byte[PAD_W-1:0] == '0);
endmodule

// File: rtl/angle_hold_latch.sv
module angle_hold_latch
  import angle_hold_pkg::*;
#(
  parameter int ANGLE_W = 14,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] count_word,
  input  logic               busy,
  input  logic               hold_n,
  input  logic [1:0]         res_sel,
  input  logic               hi_en_n,
  input  logic               lo_en_n,
  output logic [BYTE_W-1:0]  hi_byte,
  output logic               hi_oe,
  output logic [BYTE_W-1:0]  lo_byte,
  output logic               lo_oe
);
  logic               open_w;
  logic               inh_lock_w;
  logic               busy_fell_w;
  logic [ANGLE_W-1:0] held_w;
  logic [1:0]         res_w;

  hold_lock_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .busy(busy), .hold_n(hold_n),
    .open_o(open_w), .inh_lock_o(inh_lock_w), .busy_fell_o(busy_fell_w));

  word_holder #(.WORD_W(ANGLE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .open_i(open_w), .word_i(count_word),
    .held_o(held_w));

  res_capture u_res (
    .clk(clk), .rst_n(rst_n), .take_i(busy_fell_w), .res_sel(res_sel),
    .res_o(res_w));

  byte_lanes #(.ANGLE_W(ANGLE_W), .BYTE_W(BYTE_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .held_i(held_w), .res_i(res_w),
    .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .hi_byte(hi_byte), .hi_oe(hi_oe), .lo_byte(lo_byte), .lo_oe(lo_oe));

  // R2: idle and no hold means the counter value is captured
  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold_n) |=> (held_w == $past(count_word)));
  // R4: busy freezes the held word
  assert_busy_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(held_w));
  // R3: an engaged hold freezes the held word
  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && inh_lock_w) |=> $stable(held_w));
  // R5: the first idle edge under a fresh hold still captures one word
  assert_deferred_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold_n && !inh_lock_w) |=> (held_w == $past(count_word)));
  // R9: resolution moves only on the end of a busy pulse
  assert_res_only_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_fell_w |=> $stable(res_w));
endmodule

// File: tb/angle_hold_latch_bench.sv
`timescale 1ns/100ps
module angle_hold_latch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] count_word = '0;
  logic        busy = 1'b0;
  logic        hold_n = 1'b1;
  logic [1:0]  res_sel = 2'b10;
  logic        hi_en_n = 1'b1;
  logic        lo_en_n = 1'b1;
  logic [7:0]  hi_byte, lo_byte;
  logic        hi_oe, lo_oe;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  angle_hold_latch u_angle_hold_latch (
    .clk(clk), .rst_n(rst_n), .count_word(count_word), .busy(busy),
    .hold_n(hold_n), .res_sel(res_sel), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .hi_byte(hi_byte), .hi_oe(hi_oe), .lo_byte(lo_byte), .lo_oe(lo_oe));

  // Behavioural reference: word, resolution, whether a hold has taken hold.
  int m_word, m_res;
  bit m_engaged, m_prev_busy, m_frozen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = 0; m_res = 2; m_engaged = 0; m_prev_busy = 0;
    end else begin
      if (busy) m_frozen = 1;
      else if (!hold_n && m_engaged) m_frozen = 1;
      else m_frozen = 0;
      if (!m_frozen) m_word = int'(count_word);
      if (hold_n) m_engaged = 0;
      else if (!busy) m_engaged = 1;
      if (m_prev_busy && !busy) m_res = int'(res_sel);
      m_prev_busy = busy;
    end
  end

  function automatic int exp_hi();
    return hi_en_n ? 0 : (m_word >> 6) & 255;
  endfunction

  function automatic int exp_lo();
    int w, keep, low;
    if (lo_en_n) return 0;
    w = (m_res == 0) ? 10 : (m_res == 1) ? 12 : 14;
    keep = w - 8;
    low = m_word & 63;
    low = (low >> (6 - keep)) << (6 - keep);
    return low << 2;
  endfunction

  task automatic compare();
    vectors++;
    if (int'(hi_byte) != exp_hi() || hi_oe != !hi_en_n) begin
      miscompares++;
      $display("FAIL %s hi: actual %02h oe %0d expected %02h oe %0d", cur_req,
               hi_byte, hi_oe, exp_hi(), !hi_en_n);
    end
    if (int'(lo_byte) != exp_lo() || lo_oe != !lo_en_n) begin
      miscompares++;
      $display("FAIL %s lo: actual %02h oe %0d expected %02h oe %0d", cur_req,
               lo_byte, lo_oe, exp_lo(), !lo_en_n);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] c, input logic b, input logic h,
                      input logic [1:0] r, input logic he, input logic le);
    count_word = c; busy = b; hold_n = h; res_sel = r; hi_en_n = he; lo_en_n = le;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [13:0] rnd();
    return 14'($urandom);
  endfunction

  initial begin
    logic [13:0] a, d;
    @(negedge clk);
    // R1: reset state visible through both bytes
    cur_req = "R1";
    step(14'h3FFF, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R1 hi during reset", int'(hi_byte), 0);
    chk("R1 lo during reset", int'(lo_byte), 0);
    chk("R1 oe follows enable", int'(hi_oe), 1);
    rst_n = 1'b1;
    step(14'h0000, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R1 first word", int'(hi_byte), 0);

    // R2, R7, R8: transparent following, res_sel change ignored without busy (R9)
    cur_req = "R2";
    for (int i = 0; i < 24; i++) step(rnd(), 1'b0, 1'b1, 2'(i), 1'b0, 1'b0);
    step(14'h2A55, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R7 hi byte of 2A55", int'(hi_byte), 8'hA9);
    chk("R8 lo byte of 2A55 at 14-bit", int'(lo_byte), 8'h54);

    // R3: hold freezes first sampled word
    cur_req = "R3";
    a = 14'h1234;
    step(a, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(rnd(), 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R3 held hi", int'(hi_byte), int'(a[13:6]));
    chk("R3 held lo", int'(lo_byte), int'({a[5:0], 2'b00}));

    // R6: release captures
    cur_req = "R6";
    d = 14'h0ABC;
    step(d, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
    chk("R6 release capture", int'(hi_byte), int'(d[13:6]));

    // R4: busy freezes, even with hold toggling
    cur_req = "R4";
    for (int i = 0; i < 6; i++) step(rnd(), 1'b1, 1'(i), 2'b10, 1'b0, 1'b0);
    chk("R4 busy hold", int'(hi_byte), int'(d[13:6]));
    step(14'h3C00, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
    chk("R4 capture after busy", int'(hi_byte), 8'hF0);

    // R5: hold arriving inside busy is deferred
    cur_req = "R5";
    step(14'h0100, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0);
    step(14'h0200, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    step(14'h0300, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R5 no capture in busy", int'(hi_byte), 8'hF0);
    step(14'h0FC0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R5 one capture after busy", int'(hi_byte), 8'h3F);
    step(14'h3FC0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    step(14'h1FC0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R5 frozen afterwards", int'(hi_byte), 8'h3F);
    // hold engaged before busy, released during busy
    step(14'h2000, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    step(14'h2100, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0);
    chk("R4 release inside busy stays frozen", int'(hi_byte), 8'h3F);
    step(14'h2200, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
    chk("R6 capture once busy ends", int'(hi_byte), 8'h88);

    // R9: resolution codes captured at busy fall, with an all-ones word
    cur_req = "R9";
    step(14'h3FFF, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R9 res ignored without busy fall", int'(lo_byte), 8'hFC);
    step(14'h3FFF, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    step(14'h3FFF, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R8 10-bit mask", int'(lo_byte), 8'hC0);
    chk("R7 hi all ones", int'(hi_byte), 8'hFF);
    step(14'h3FFF, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
    step(14'h3FFF, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0);
    chk("R8 12-bit mask", int'(lo_byte), 8'hF0);
    step(14'h3FFF, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0);
    step(14'h3FFF, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0);
    chk("R9 code 11 is 14-bit", int'(lo_byte), 8'hFC);

    // R10: enables high turn bytes off
    cur_req = "R10";
    step(14'h3FFF, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0);
    chk("R10 hi off", int'({hi_oe, hi_byte}), 0);
    step(14'h3FFF, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1);
    chk("R10 lo off", int'({lo_oe, lo_byte}), 0);

    // Mixed soak: every requirement against the reference each clock
    cur_req = "mixed";
    for (int i = 0; i < 3000; i++)
      step(rnd(), ($urandom % 4) == 0, ($urandom % 3) != 0, 2'($urandom),
           ($urandom % 4) == 0, ($urandom % 4) == 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule